// File: doc/BRIEF.md
# SPI Register Target with Run-Time 3-Wire / 4-Wire Selection

This block is the device side of a SPI register port. It sits on a system clock, oversamples the serial clock, chip select and serial data lines, and exposes a small register file. A host frame is an instruction of sixteen bits followed by one data byte. The host either writes that byte into a register or has the block return the register's contents.

Two registers are implemented. The configuration register picks where read data leaves the block. With its bit 4 set, data goes out on a dedicated serial output. With bit 4 clear, data is driven back on the shared bidirectional data line, and the line is turned around only after the address has been received. The second register is a scratch byte for link checks. A configuration write changes the pin choice only when the next frame begins.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is a 1-bit operation flag (1 = read, 0 = write), then a 15-bit register address, then 8 data bits, all MSB first. A write commits the data byte into the addressed register.
- R2: Register 0x009 holds any byte written to it, and a read returns exactly the last value written.
- R3: Input bits are taken on rising SCLK edges. Output bits change only after falling SCLK edges, so each read bit stays steady across the high phase in which the host samples it.
- R4: When register 0x000 has bit 4 set (for example 0x3C), read data appears on `sdo` with `sdo_oe` high and `sdio_oe` low. The register reads back the full byte written.
- R5: When register 0x000 has bit 4 clear (for example 0x24), read data appears on `sdio_o` with `sdio_oe` high and `sdo_oe` low. The register reads back the full byte written.
- R6: Both output enables stay low through all 16 instruction bits. In a read, the selected enable is high for the 8 data bits. It drops after the falling SCLK edge that follows the last data bit, even while CSB is still low.
- R7: Raising CSB ends the frame at once. A partial write is discarded, both output enables go low, and the next frame starts again at the first instruction bit.
- R8: After `rst`, register 0x000 is 0x10 (4-wire operation), register 0x009 is 0x00, and both output enables are low.
- R9: A write to register 0x000 changes the output pin choice at the start of the next frame, never within the frame that is running.
- R10: A read of any address other than 0x000 and 0x009 returns 0x00. A write to such an address changes no register.
- R11: SCLK edges after the 24th bit of a frame are ignored. A long write commits only its first data byte, and only to the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| csb_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data input; the shared line's input side in 3-wire operation |
| sdo | output | 1 | Dedicated serial data output (4-wire) |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdio_o | output | 1 | Shared-line output data (3-wire) |
| sdio_oe | output | 1 | Output enable for the shared line |

## Verification
The hardest cases to reach from the ports are the turnaround edges of the shared line and the rule that a mode change waits for the next frame. The enable must stay low up to the last address bit and must drop with chip select still low. The stimulus samples both enables before every rising edge. It checks them again half a period after the last falling edge, before CSB is raised. The mode is switched both ways in the middle of a run, with reads of random scratch values in each mode. Frames are also cut short inside the instruction and inside the data byte, and frames are run past 24 bits, to show that only complete frames commit.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int ADDR_W       = 15;
  localparam int DATA_W       = 8;
  localparam int SYNC_STAGES  = 2;
  localparam int CFG_ADDR     = 0;
  localparam int SCRATCH_ADDR = 9;
  localparam logic [DATA_W-1:0] CFG_RST     = 8'h10;
  localparam logic [DATA_W-1:0] SCRATCH_RST = 8'h00;
  localparam int WIRE4_BIT    = 4;

  typedef enum logic {
    MODE_3W = 1'b0,
    MODE_4W = 1'b1
  } wire_mode_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csb_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              drive_bit,
  output logic              drive_en
);
  localparam int INSTR_W = ADDR_W + 1;
  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              sclk_d;
  logic              active, rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [INSTR_W-1:0] shreg;
  logic              is_read;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tx_shift;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign active  = ~csb_s;
  assign rise    = active & sclk_s & ~sclk_d;
  assign fall    = active & ~sclk_s & sclk_d;
  assign rd_addr = {shreg[ADDR_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      is_read   <= 1'b0;
      addr_q    <= '0;
      tx_shift  <= '0;
      drive_bit <= 1'b0;
      drive_en  <= 1'b0;
    end else if (!active) begin
      bit_cnt  <= '0;
      is_read  <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      if (rise && bit_cnt != CNT_W'(FRAME_W)) begin
        shreg   <= {shreg[INSTR_W-2:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(INSTR_W - 1)) begin
          is_read  <= shreg[INSTR_W-2];
          addr_q   <= rd_addr;
          tx_shift <= rd_data;
        end
      end
      if (fall && is_read) begin
        if (bit_cnt == CNT_W'(FRAME_W)) begin
          drive_en <= 1'b0;
        end else if (bit_cnt >= CNT_W'(INSTR_W)) begin
          drive_bit <= tx_shift[DATA_W-1];
          tx_shift  <= {tx_shift[DATA_W-2:0], 1'b0};
          drive_en  <= 1'b1;
        end
      end
    end
  end

  assign wr_en   = rise && !is_read && (bit_cnt == CNT_W'(FRAME_W - 1));
  assign wr_addr = addr_q;
  assign wr_data = {shreg[DATA_W-2:0], sdi_s};

  // R3: output data only moves after a falling serial clock edge
  a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(drive_bit));

  // R6: enable only in the data phase of a read
  a_r6_drive_window: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (bit_cnt >= CNT_W'(INSTR_W)) && is_read);

  // R7: deselect clears the frame
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (rst)
    csb_s |=> (bit_cnt == '0) && !drive_en);
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CFG_ADDR = 0,
  parameter int SCRATCH_ADDR = 9,
  parameter logic [DATA_W-1:0] CFG_RST = '0,
  parameter logic [DATA_W-1:0] SCRATCH_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_q
);
  logic [DATA_W-1:0] scratch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RST;
      scratch_q <= SCRATCH_RST;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(CFG_ADDR))     cfg_q     <= wr_data;
      if (wr_addr == ADDR_W'(SCRATCH_ADDR)) scratch_q <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_W'(CFG_ADDR))          rd_data = cfg_q;
    else if (rd_addr == ADDR_W'(SCRATCH_ADDR)) rd_data = scratch_q;
    else                                       rd_data = '0;
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_SYNC   = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic csb_n,
  input  logic sdio_i,
  output logic sdo,
  output logic sdo_oe,
  output logic sdio_o,
  output logic sdio_oe
);
  logic [2:0] pins_s;
  logic sclk_s, csb_s, sdi_s;
  logic [P_ADDR_W-1:0] rd_addr, wr_addr;
  logic [P_DATA_W-1:0] rd_data, wr_data, cfg_q;
  logic wr_en, drive_bit, drive_en;
  wire_mode_e mode_act;

  spi_in_sync #(.W(3), .STAGES(P_SYNC), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sdio_i, csb_n, sclk}), .q(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign csb_s  = pins_s[1];
  assign sdi_s  = pins_s[2];

  spi_frame_engine #(.ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W)) u_engine (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .csb_s(csb_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .drive_bit(drive_bit), .drive_en(drive_en)
  );

  spi_regfile #(
    .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W), .CFG_ADDR(CFG_ADDR),
    .SCRATCH_ADDR(SCRATCH_ADDR), .CFG_RST(CFG_RST), .SCRATCH_RST(SCRATCH_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_q(cfg_q)
  );

  // pin choice is latched only while deselected
  always_ff @(posedge clk) begin
    if (rst)        mode_act <= wire_mode_e'(CFG_RST[WIRE4_BIT]);
    else if (csb_s) mode_act <= wire_mode_e'(cfg_q[WIRE4_BIT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
    end else begin
      sdo     <= drive_bit;
      sdio_o  <= drive_bit;
      sdo_oe  <= drive_en && (mode_act == MODE_4W);
      sdio_oe <= drive_en && (mode_act == MODE_3W);
    end
  end

  // R9: pin choice frozen while a frame runs
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (!csb_s && !$past(csb_s)) |-> $stable(mode_act));

  // R7: pins released after deselect has propagated
  a_r7_pins_released: assert property (@(posedge clk) disable iff (rst)
    (csb_s && $past(csb_s) && $past(csb_s, 2)) |-> (!sdo_oe && !sdio_oe));
endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int HALF = 8;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csb_n = 1'b1, sdio_i = 1'b0;
  logic sdo, sdo_oe, sdio_o, sdio_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] m_cfg, m_scr;

  always #4 clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rst(rst), .sclk(sclk), .csb_n(csb_n), .sdio_i(sdio_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [14:0] a);
    if (a == 15'd0) return m_cfg;
    if (a == 15'd9) return m_scr;
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_cfg = 8'h10;
    m_scr = 8'h00;
  endtask

  // one host frame; stop_at cuts it short before that bit index
  task automatic frame(input bit rd, input logic [14:0] a, input logic [7:0] wd,
                       input int ndata, input int stop_at,
                       output logic [7:0] rdat, output bit ok_oe,
                       output bit ok_stable, output bit ok_rel);
    logic [15:0] instr;
    bit w4;
    int sent;
    instr = {rd, a};
    w4 = m_cfg[4];
    rdat = '0; ok_oe = 1; ok_stable = 1; ok_rel = 1; sent = 0;
    csb_n = 1'b0;
    hold(HALF);
    for (int i = 0; i < 16 + ndata; i++) begin
      if (i == stop_at) break;
      if (i < 16)      sdio_i = instr[15-i];
      else if (i < 24) sdio_i = rd ? 1'b0 : wd[23-i];
      else             sdio_i = 1'b1;
      hold(HALF);
      if (i < 16 && (sdo_oe || sdio_oe)) ok_oe = 0;
      if (rd && i >= 16 && i < 24) begin
        if (w4 ? !(sdo_oe && !sdio_oe) : !(sdio_oe && !sdo_oe)) ok_oe = 0;
        rdat[23-i] = w4 ? sdo : sdio_o;
      end
      sclk = 1'b1;
      hold(HALF);
      if (rd && i >= 16 && i < 24 && ((w4 ? sdo : sdio_o) !== rdat[23-i])) ok_stable = 0;
      sclk = 1'b0;
      sent++;
    end
    hold(HALF);
    if (sdo_oe || sdio_oe) ok_rel = 0;
    csb_n = 1'b1;
    hold(HALF);
    if (!rd && sent >= 24) begin
      if (a == 15'd0) m_cfg = wd;
      if (a == 15'd9) m_scr = wd;
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] wd);
    logic [7:0] r; bit o1, o2, o3;
    frame(1'b0, a, wd, 8, 999, r, o1, o2, o3);
  endtask

  task automatic read_chk(input string req, input logic [14:0] a);
    logic [7:0] r; bit o1, o2, o3; logic [7:0] e;
    e = exp_read(a);
    frame(1'b1, a, 8'h00, 8, 999, r, o1, o2, o3);
    chk(req, $sformatf("read 0x%0h", a), r, e);
    if (!o1) chk(req, "output enables during frame", 0, 1);
    if (!o2) chk("R3", "bit moved during high phase", 0, 1);
    if (!o3) chk("R6", "enable not dropped after last bit", 0, 1);
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] r, wd;
    logic [14:0] a;
    bit o1, o2, o3;
    void'($urandom(32'h5EED1234));
    model_reset();
    hold(5);
    rst = 1'b0;
    hold(6);

    // R8 reset state
    chk("R8", "sdo_oe after reset", sdo_oe, 0);
    chk("R8", "sdio_oe after reset", sdio_oe, 0);
    read_chk("R8", 15'd0);
    read_chk("R8", 15'd9);

    // R1 R2 directed
    do_write(15'd9, 8'hA5);
    read_chk("R1", 15'd9);
    do_write(15'd9, 8'h01);
    read_chk("R2", 15'd9);

    // R4 full-byte config in 4-wire, plus turnaround checks
    do_write(15'd0, 8'h3C);
    read_chk("R4", 15'd0);
    frame(1'b1, 15'd9, 8'h00, 8, 999, r, o1, o2, o3);
    chk("R4", "4-wire enables", o1, 1);
    chk("R6", "4-wire release before CSB", o3, 1);
    chk("R3", "4-wire bits steady while high", o2, 1);

    // R2 R10 random in 4-wire
    for (int k = 0; k < 10; k++) begin
      wd = 8'($urandom);
      do_write(15'd9, wd);
      read_chk("R2", 15'd9);
      a = 15'($urandom_range(1, 32767));
      if (a == 15'd9) a = 15'd10;
      read_chk("R10", a);
      do_write(a, 8'($urandom));
      read_chk("R10", 15'd9);
      read_chk("R10", 15'd0);
    end

    // R5 R9: switch to 3-wire; next frame uses the shared line
    do_write(15'd0, 8'h24);
    frame(1'b1, 15'd9, 8'h00, 8, 999, r, o1, o2, o3);
    chk("R9", "first frame after switch data", r, m_scr);
    chk("R5", "3-wire enables", o1, 1);
    chk("R6", "3-wire line released before CSB", o3, 1);
    read_chk("R5", 15'd0);
    for (int k = 0; k < 6; k++) begin
      wd = 8'($urandom);
      do_write(15'd9, wd);
      read_chk("R5", 15'd9);
    end

    // R7 abort inside data byte and inside instruction
    frame(1'b0, 15'd9, 8'h5A, 8, 20, r, o1, o2, o3);
    read_chk("R7", 15'd9);
    frame(1'b0, 15'd0, 8'h3C, 8, 10, r, o1, o2, o3);
    read_chk("R7", 15'd0);
    frame(1'b1, 15'd9, 8'h00, 8, 19, r, o1, o2, o3);
    chk("R7", "sdio_oe after read abort", sdio_oe, 0);
    chk("R7", "sdo_oe after read abort", sdo_oe, 0);
    read_chk("R7", 15'd9);

    // R11 long frame: only first byte, only addressed register
    frame(1'b0, 15'd9, 8'h3E, 16, 999, r, o1, o2, o3);
    read_chk("R11", 15'd9);
    read_chk("R11", 15'd0);

    // R4 R9 back to 4-wire
    do_write(15'd0, 8'h3C);
    read_chk("R4", 15'd9);
    read_chk("R4", 15'd0);

    // R8 reset from a changed state
    do_write(15'd0, 8'h24);
    do_write(15'd9, 8'hC3);
    hold(2);
    rst = 1'b1;
    hold(4);
    rst = 1'b0;
    model_reset();
    hold(6);
    read_chk("R8", 15'd0);
    read_chk("R8", 15'd9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule